// File: doc/BRIEF.md
# Duplicated Dual-Rail Register Merge Stage

This block models one stage of a pipeline in which every register exists twice, as an original copy and a shadow copy. Each copy holds a word of dual-rail bits. Both copies feed a bank of state-holding agreement gates, one gate per rail, and that bank produces the merged word seen by the next stage. A rail of the merged word changes only when both copies show the same level on that rail. A fault confined to one copy therefore cannot reach the merged output.

Each copy's register takes two sleep requests, one from each copy's completion logic. The register clears to NULL only when both requests are high, so a single corrupted sleep line cannot flush data early. While a register slot is awake and holds NULL, it accepts the next valid dual-rail code. It keeps that code until the joint sleep clears it.

The model is cycle-based: each state-holding gate updates on the clock edge, and this stands in for the settling of the clockless gates. An injection port overwrites one copy's register with an arbitrary rail pattern. It stands for the unknown state a copy wakes up in after its supply is restored.

Top module: `dmr_merge_stage`

## Requirements
- R1: While rst_ni is low, both register copies and the merged output read all zero (NULL in every slot). They still read zero on the first cycle after release, while both sleep inputs are high.
- R2: Slot i occupies bits [2i+1:2i]. 2'b00 is NULL, 2'b01 is value 0 (rail0 high), 2'b10 is value 1 (rail1 high). A slot that holds NULL while not both sleeps are high captures a valid input code on the next clock edge.
- R3: A merged rail rises one cycle after the corresponding rail is high in both copies, and never rises unless both copies had it high.
- R4: A slot holding a data code keeps it while the sleeps are not both high, whatever its input does.
- R5: With exactly one sleep input high, neither copy is cleared.
- R6: When both sleep inputs are high and no injection is requested, both copies read NULL after the next edge. The merged output reads NULL one cycle after that.
- R7: A rail forced high in only one copy by injection (inj_sel_i 0 selects the original copy, 1 the shadow copy) never shows on the merged output, and rails both copies hold stay asserted.
- R8: While the copies disagree on a rail, the merged rail keeps its previous value, whether that value is high or low. It falls only when both copies have that rail low.
- R9: An input slot code of 2'b11 is never captured; the slot stays NULL.
- R10: Slots are independent: each slot captures and holds on its own, so a word may fill one slot at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Evaluation clock for the state-holding gates |
| rst_ni | input | 1 | Active-low asynchronous reset to NULL |
| data_a_i | input | 2*W | Dual-rail input word of the original copy |
| data_b_i | input | 2*W | Dual-rail input word of the shadow copy |
| slp_a_i | input | 1 | Sleep request from the original copy's completion logic |
| slp_b_i | input | 1 | Sleep request from the shadow copy's completion logic |
| inj_en_i | input | 1 | Overwrite one copy's register with inj_pat_i this cycle |
| inj_sel_i | input | 1 | Copy to corrupt: 0 original, 1 shadow |
| inj_pat_i | input | 2*W | Rail pattern forced into the selected copy |
| reg_a_o | output | 2*W | Original copy register contents |
| reg_b_o | output | 2*W | Shadow copy register contents |
| merged_o | output | 2*W | Agreement-gated merged dual-rail word |

## Verification
Two events can fall in the same cycle: a corruption that lands in one copy, and a merged output that is still settling on the agreed data. The bench injects an all-ones pattern into the original copy right after both copies agree. It then expects the merged word to stay on the agreed code while that copy shows both rails high in every slot. A second collision pairs a shadow copy that is wiped to NULL with a merged word that must keep its high rails until a joint sleep clears both copies.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  typedef enum logic [1:0] {
    DR_NULL = 2'b00,
    DR_ZERO = 2'b01,
    DR_ONE  = 2'b10,
    DR_BAD  = 2'b11
  } dr_code_e;

  function automatic logic is_data(input logic [1:0] c);
    return ^c;
  endfunction
endpackage

// File: rtl/dr_reg.sv
module dr_reg #(
  parameter int W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*W-1:0] d_i,
  input  logic           slp_own_i,
  input  logic           slp_peer_i,
  input  logic           inj_en_i,
  input  logic [2*W-1:0] inj_pat_i,
  output logic [2*W-1:0] q_o
);
  import dmr_pkg::*;

  logic slp_both;
  assign slp_both = slp_own_i & slp_peer_i;

  for (genvar i = 0; i < W; i++) begin : g_slot
    logic [1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= DR_NULL;
      else if (inj_en_i)                    q <= inj_pat_i[2*i +: 2];
      else if (slp_both)                    q <= DR_NULL;
      else if (q == DR_NULL && is_data(d_i[2*i +: 2]))
                                            q <= d_i[2*i +: 2];
    end
    assign q_o[2*i +: 2] = q;
  end
endmodule

// File: rtl/c_gate.sv
module c_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic y_o
);
  // hysteresis: set on all-high, clear on all-low, else hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            y_o <= 1'b0;
    else if (a_i && b_i)    y_o <= 1'b1;
    else if (!a_i && !b_i)  y_o <= 1'b0;
  end
endmodule

// File: rtl/rail_merge.sv
module rail_merge #(
  parameter int W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*W-1:0] a_i,
  input  logic [2*W-1:0] b_i,
  output logic [2*W-1:0] y_o
);
  localparam int NR = 2 * W;

  for (genvar r = 0; r < NR; r++) begin : g_rail
    c_gate u_c (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (a_i[r]),
      .b_i   (b_i[r]),
      .y_o   (y_o[r])
    );
  end
endmodule

// File: rtl/dmr_merge_stage.sv
module dmr_merge_stage #(
  parameter int W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*W-1:0] data_a_i,
  input  logic [2*W-1:0] data_b_i,
  input  logic           slp_a_i,
  input  logic           slp_b_i,
  input  logic           inj_en_i,
  input  logic           inj_sel_i,
  input  logic [2*W-1:0] inj_pat_i,
  output logic [2*W-1:0] reg_a_o,
  output logic [2*W-1:0] reg_b_o,
  output logic [2*W-1:0] merged_o
);
  logic inj_a, inj_b;
  assign inj_a = inj_en_i & ~inj_sel_i;
  assign inj_b = inj_en_i &  inj_sel_i;

  dr_reg #(.W(W)) u_reg_a (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       (data_a_i),
    .slp_own_i (slp_a_i),
    .slp_peer_i(slp_b_i),
    .inj_en_i  (inj_a),
    .inj_pat_i (inj_pat_i),
    .q_o       (reg_a_o)
  );

  dr_reg #(.W(W)) u_reg_b (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       (data_b_i),
    .slp_own_i (slp_b_i),
    .slp_peer_i(slp_a_i),
    .inj_en_i  (inj_b),
    .inj_pat_i (inj_pat_i),
    .q_o       (reg_b_o)
  );

  rail_merge #(.W(W)) u_merge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (reg_a_o),
    .b_i   (reg_b_o),
    .y_o   (merged_o)
  );
endmodule

// File: rtl/dmr_merge_stage_chk.sv
module dmr_merge_stage_chk #(
  parameter int W = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           slp_a_i,
  input logic           slp_b_i,
  input logic           inj_en_i,
  input logic [2*W-1:0] reg_a_o,
  input logic [2*W-1:0] reg_b_o,
  input logic [2*W-1:0] merged_o
);
  a_r3_rise_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (merged_o & ~$past(merged_o) & ~($past(reg_a_o) & $past(reg_b_o))) == '0);

  a_r8_fall_needs_both_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~merged_o & $past(merged_o) & ($past(reg_a_o) | $past(reg_b_o))) == '0);

  a_r6_joint_sleep_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slp_a_i && slp_b_i && !inj_en_i) |=> (reg_a_o == '0 && reg_b_o == '0));

  a_r5_no_clear_awake_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(slp_a_i && slp_b_i) && !inj_en_i) |=> (($past(reg_a_o) & ~reg_a_o) == '0));

  a_r5_no_clear_awake_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(slp_a_i && slp_b_i) && !inj_en_i) |=> (($past(reg_b_o) & ~reg_b_o) == '0));
endmodule

bind dmr_merge_stage dmr_merge_stage_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .slp_a_i (slp_a_i),
  .slp_b_i (slp_b_i),
  .inj_en_i(inj_en_i),
  .reg_a_o (reg_a_o),
  .reg_b_o (reg_b_o),
  .merged_o(merged_o)
);

// File: tb/dmr_merge_stage_tb_top.sv
module dmr_merge_stage_tb_top;
  localparam int W  = 4;
  localparam int BW = 2 * W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [BW-1:0] data_a, data_b, inj_pat;
  logic slp_a, slp_b, inj_en, inj_sel;
  logic [BW-1:0] reg_a, reg_b, merged;

  always #2ns clk = ~clk;

  dmr_merge_stage #(.W(W)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .data_a_i (data_a),
    .data_b_i (data_b),
    .slp_a_i  (slp_a),
    .slp_b_i  (slp_b),
    .inj_en_i (inj_en),
    .inj_sel_i(inj_sel),
    .inj_pat_i(inj_pat),
    .reg_a_o  (reg_a),
    .reg_b_o  (reg_b),
    .merged_o (merged)
  );

  typedef struct {
    int            due;
    int            kind;   // 0 merged, 1 copy a, 2 copy b
    logic [BW-1:0] exp;
    string         tag;
  } exp_t;

  exp_t sb_q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [BW-1:0] enc(input int v);
    logic [BW-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic expect_at(input int kind, input int off, input logic [BW-1:0] e, input string tag);
    exp_t it;
    it.due = cyc + off;
    it.kind = kind;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drive(input logic [BW-1:0] da, input logic [BW-1:0] db,
                       input logic sa, input logic sb,
                       input logic ie, input logic is, input logic [BW-1:0] ip);
    @(negedge clk);
    data_a = da; data_b = db; slp_a = sa; slp_b = sb;
    inj_en = ie; inj_sel = is; inj_pat = ip;
  endtask

  // monitor: pop every item that has come due and compare
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t it;
      logic [BW-1:0] got;
      it = sb_q.pop_front();
      got = (it.kind == 0) ? merged : (it.kind == 1) ? reg_a : reg_b;
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d cyc=%0d got=%h exp=%h", it.tag, it.kind, cyc, got, it.exp);
      end
    end
  end

  initial begin
    logic [BW-1:0] e5, ea, e3;
    e5 = enc(5); ea = enc(10); e3 = enc(3);
    data_a = '0; data_b = '0; slp_a = 1; slp_b = 1;
    inj_en = 0; inj_sel = 0; inj_pat = '0;
    #1ns;
    total++;
    if (reg_a !== '0 || reg_b !== '0 || merged !== '0) begin
      bad++;
      $display("FAIL R1 in reset got=%h/%h/%h exp=0", reg_a, reg_b, merged);
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;

    drive('0, '0, 1, 1, 0, 0, '0);
    expect_at(1, 1, '0, "R1"); expect_at(2, 1, '0, "R1"); expect_at(0, 1, '0, "R1");
    drive(e5, e5, 0, 0, 0, 0, '0);
    expect_at(1, 1, e5, "R2"); expect_at(2, 1, e5, "R2"); expect_at(0, 2, e5, "R3");
    drive(ea, ea, 0, 0, 0, 0, '0);
    expect_at(1, 1, e5, "R4"); expect_at(0, 2, e5, "R4");
    drive(ea, ea, 1, 0, 0, 0, '0);
    expect_at(1, 1, e5, "R5");
    drive(ea, ea, 0, 1, 0, 0, '0);
    expect_at(2, 1, e5, "R5"); expect_at(0, 2, e5, "R5");
    drive(ea, ea, 1, 1, 0, 0, '0);
    expect_at(1, 1, '0, "R6"); expect_at(2, 1, '0, "R6"); expect_at(0, 2, '0, "R6");
    drive(ea, ea, 0, 0, 0, 0, '0);
    expect_at(1, 1, ea, "R2"); expect_at(0, 2, ea, "R3");
    drive(ea, ea, 0, 0, 0, 0, '0);
    // corrupt original copy while shadow holds agreed data
    drive(ea, ea, 0, 0, 1, 0, '1);
    expect_at(1, 1, '1, "R7"); expect_at(0, 2, ea, "R7");
    drive(ea, ea, 0, 0, 0, 0, '0);
    expect_at(2, 1, ea, "R7"); expect_at(0, 2, ea, "R7");
    drive(ea, ea, 1, 1, 0, 0, '0);
    expect_at(1, 1, '0, "R6"); expect_at(0, 2, '0, "R6");
    // disagreement while rising
    drive(e3, '0, 0, 0, 0, 0, '0);
    expect_at(1, 1, e3, "R8"); expect_at(2, 1, '0, "R8"); expect_at(0, 2, '0, "R8");
    drive(e3, '0, 0, 0, 0, 0, '0);
    expect_at(0, 2, '0, "R8");
    drive(e3, e3, 0, 0, 0, 0, '0);
    expect_at(2, 1, e3, "R2"); expect_at(0, 2, e3, "R3");
    drive(e3, e3, 0, 0, 0, 0, '0);
    // wipe shadow copy: merged must hold high rails
    drive(e3, e3, 0, 0, 1, 1, '0);
    expect_at(2, 1, '0, "R7"); expect_at(0, 2, e3, "R8");
    drive(e3, '0, 0, 0, 0, 0, '0);
    expect_at(0, 2, e3, "R8");
    drive('0, '0, 1, 1, 0, 0, '0);
    expect_at(1, 1, '0, "R6"); expect_at(0, 2, '0, "R8");
    drive(8'h03, 8'h03, 0, 0, 0, 0, '0);
    expect_at(1, 1, '0, "R9"); expect_at(2, 1, '0, "R9");
    drive(8'h02, 8'h02, 0, 0, 0, 0, '0);
    expect_at(1, 1, 8'h02, "R10"); expect_at(0, 2, 8'h02, "R10");
    drive(8'h06, 8'h06, 0, 0, 0, 0, '0);
    expect_at(1, 1, 8'h06, "R10"); expect_at(0, 2, 8'h06, "R10");
    drive(8'h05, 8'h05, 0, 0, 0, 0, '0);
    expect_at(2, 1, 8'h06, "R4");
    repeat (4) drive(8'h05, 8'h05, 0, 0, 0, 0, '0);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard left=%0d exp=0", sb_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20us;
    total++; bad++;
    $display("FAIL watchdog expired got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule